// File: doc/BRIEF.md
# Serial Receive Data Output Port

This block hands demodulated receive bits to an external controller as a serial line, together with a bit clock and a data-valid envelope. A demodulator upstream pulses a strobe once per bit and supplies that bit. The port forwards the bits in the order they arrive. Bytes supplied least significant bit first therefore leave least significant bit first.

While the receive enable is low, the port stays in standby. Once acquisition completes, the bit clock follows the strobes through the preamble and header bits, but the data line stays at zero. The envelope opens only when the header CRC result arrives and either shows a pass or the ignore-errors setting is on. A header length of zero also keeps it shut. The envelope closes on the first of three events:

- the whole payload has been shifted out,
- PN tracking is lost,
- the enable is withdrawn.

A configuration bit inverts the polarity of the envelope. The port has no link to any transmit logic, so receive and transmit can run at the same time.

Top module: `rxd_serial_port`

## Requirements
- R1: While `rx_en` is low, `ser_clk` is held at 1, `ser_data` at 0 and the envelope is inactive. `acq_done` pulses and strobes have no effect.
- R2: From the clock edge at which `acq_done` is sampled with `rx_en` high, each strobe sampled on an edge drives `ser_clk` to 0 at that edge. `ser_clk` returns to 1 `HALF_CYC` edges later. Strobes must be at least `2*HALF_CYC` cycles apart.
- R3: Before the header CRC result, `ser_data` stays 0 and the envelope stays inactive. The envelope becomes active at the edge that samples `crc_done` with `crc_ok`=1 and a nonzero `hdr_len`.
- R4: Inside the envelope, each strobed bit appears on `ser_data` at the edge that samples its strobe. It stays stable until the next strobe, so it is settled at the rising edge of `ser_clk`. Bits leave in arrival order.
- R5: After `hdr_len`*8 bits, the envelope stays active through the first cycle in which `ser_clk` is back at 1 after the last bit. It goes inactive, with `ser_data` at 0, on the following edge. Outside the envelope `ser_data` is always 0.
- R6: `pn_lost` sampled while the envelope is active closes it at that edge, forces `ser_data` to 0 and `ser_clk` to 1, and returns the port to waiting for `acq_done`.
- R7: `rx_en` dropping while the envelope is active closes it at the edge that samples it, with `ser_clk` at 1.
- R8: With `cfg_ignore_crc`=0, a `crc_done` pulse with `crc_ok`=0 leaves the envelope inactive. The port then waits for a new `acq_done`, and strobes no longer move `ser_clk`.
- R9: With `cfg_ignore_crc`=1, a failed header CRC opens the envelope exactly as a pass does, and the full payload is shifted out.
- R10: `ser_valid` is 1 for an active envelope when `cfg_env_low`=0, and 0 for an active envelope when `cfg_env_low`=1.
- R11: A `hdr_len` of zero with a passing CRC leaves the envelope inactive and returns the port to waiting for `acq_done`.
- R12: A strobe sampled in the same cycle as `pn_lost` is discarded. `ser_data` is 0 and `ser_clk` is 1 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receive enable; low means standby |
| acq_done | input | 1 | One-cycle pulse: acquisition complete |
| dem_stb | input | 1 | One-cycle strobe: a demodulated bit is ready |
| dem_bit | input | 1 | Demodulated bit qualified by `dem_stb` |
| hdr_len | input | LEN_W | Payload length in bytes from the header |
| crc_done | input | 1 | One-cycle pulse: header CRC check finished |
| crc_ok | input | 1 | Header CRC passed, qualified by `crc_done` |
| pn_lost | input | 1 | PN tracking lost |
| cfg_ignore_crc | input | 1 | Open the envelope even on a header CRC failure |
| cfg_env_low | input | 1 | Envelope active level is low |
| ser_data | output | 1 | Serial data out |
| ser_clk | output | 1 | Gated bit clock |
| ser_valid | output | 1 | Data-valid envelope |

## Verification
Two events can fall in the same cycle: a data strobe and a termination, whether `pn_lost` or `rx_en` dropping. The bench provokes this by raising `pn_lost` on the very edge that carries a payload strobe. It then checks that the bit is discarded: `ser_data` reads 0, `ser_clk` stays high and the envelope has closed. The last payload bit is also checked against its closing sequence. The envelope must survive the rising clock edge of that bit and close exactly one cycle later.

// File: rtl/rxd_port_pkg.sv
package rxd_port_pkg;

  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_SYNC = 2'd1,
    ST_DATA = 2'd2,
    ST_LAST = 2'd3
  } port_state_e;

  function automatic logic in_envelope(port_state_e s);
    return (s == ST_DATA) || (s == ST_LAST);
  endfunction

endpackage

// File: rtl/rxd_bitclk.sv
module rxd_bitclk #(
  parameter int HALF_CYC = 2
) (
  input  logic clk,
  input  logic rst_ns,
  input  logic run,
  input  logic stb,
  output logic bclk
);

  localparam int CW = $clog2(HALF_CYC + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          bclk_q, bclk_d;

  always_comb begin
    cnt_d  = cnt_q;
    bclk_d = bclk_q;
    if (!run) begin
      cnt_d  = '0;
      bclk_d = 1'b1;
    end else if (stb) begin
      cnt_d  = CW'(HALF_CYC);
      bclk_d = 1'b0;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == CW'(1)) bclk_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      cnt_q  <= '0;
      bclk_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_d;
      bclk_q <= bclk_d;
    end
  end

  assign bclk = bclk_q;

  // R2: a strobe while running pulls the clock low at that edge
  a_r2_fall_on_strobe: assert property (@(posedge clk) disable iff (!rst_ns)
    (run && stb) |=> !bclk_q);

  // R2: the clock never stays low beyond the half period
  a_r2_low_bounded: assert property (@(posedge clk) disable iff (!rst_ns)
    (!bclk_q && cnt_q == '0) |-> 1'b0);

endmodule

// File: rtl/rxd_ctrl.sv
module rxd_ctrl
  import rxd_port_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_ns,
  input  logic             rx_en,
  input  logic             acq_done,
  input  logic             dem_stb,
  input  logic [LEN_W-1:0] hdr_len,
  input  logic             crc_done,
  input  logic             crc_ok,
  input  logic             pn_lost,
  input  logic             cfg_ignore_crc,
  input  logic             bclk,
  output logic             run_nx,
  output logic             env_nx,
  output logic             take
);

  localparam int CNT_W = LEN_W + 3;

  port_state_e      st_q, st_d;
  logic [CNT_W-1:0] remain_q, remain_d;
  logic             crc_pass;
  logic             load_cnt;

  assign crc_pass = (crc_ok || cfg_ignore_crc) && (hdr_len != '0);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_HUNT: if (acq_done) st_d = ST_SYNC;
      ST_SYNC: begin
        if (pn_lost)       st_d = ST_HUNT;
        else if (crc_done) st_d = crc_pass ? ST_DATA : ST_HUNT;
      end
      ST_DATA: begin
        if (pn_lost) st_d = ST_HUNT;
        else if (dem_stb && remain_q == CNT_W'(1)) st_d = ST_LAST;
      end
      ST_LAST: begin
        if (pn_lost || bclk) st_d = ST_HUNT;
      end
      default: st_d = ST_HUNT;
    endcase
    if (!rx_en) st_d = ST_HUNT;
  end

  assign take     = (st_q == ST_DATA) && dem_stb && in_envelope(st_d);
  assign load_cnt = (st_q == ST_SYNC) && (st_d == ST_DATA);
  assign run_nx   = (st_d != ST_HUNT);
  assign env_nx   = in_envelope(st_d);

  always_comb begin
    remain_d = remain_q;
    if (load_cnt)  remain_d = {hdr_len, 3'b000};
    else if (take) remain_d = remain_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) st_q <= ST_HUNT;
    else         st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns)                remain_q <= '0;
    else if (load_cnt || take)  remain_q <= remain_d;
  end

  // R8: a failed CRC without the ignore setting sends the port back to hunting
  a_r8_crc_block: assert property (@(posedge clk) disable iff (!rst_ns)
    (st_q == ST_SYNC && crc_done && !crc_ok && !cfg_ignore_crc) |=> st_q == ST_HUNT);

  // R11: an empty payload never enters the data phase
  a_r11_len_zero: assert property (@(posedge clk) disable iff (!rst_ns)
    (st_q == ST_SYNC && crc_done && hdr_len == '0) |=> st_q == ST_HUNT);

  // R5: the data phase always has bits left to send
  a_r5_count_live: assert property (@(posedge clk) disable iff (!rst_ns)
    (st_q == ST_DATA) |-> remain_q != '0);

  // R1: standby from any state once the enable drops
  a_r1_standby_state: assert property (@(posedge clk) disable iff (!rst_ns)
    !rx_en |=> st_q == ST_HUNT);

endmodule

// File: rtl/rxd_drive.sv
module rxd_drive (
  input  logic clk,
  input  logic rst_ns,
  input  logic env_nx,
  input  logic take,
  input  logic dem_bit,
  input  logic cfg_env_low,
  output logic ser_data,
  output logic env_act,
  output logic ser_valid
);

  logic data_q, data_d;
  logic env_q;

  always_comb begin
    data_d = data_q;
    if (!env_nx)   data_d = 1'b0;
    else if (take) data_d = dem_bit;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      data_q <= 1'b0;
      env_q  <= 1'b0;
    end else begin
      data_q <= data_d;
      env_q  <= env_nx;
    end
  end

  assign ser_data  = data_q;
  assign env_act   = env_q;
  assign ser_valid = env_q ^ cfg_env_low;

  // R5: the data line is zero whenever the envelope is closed
  a_r5_zero_outside: assert property (@(posedge clk) disable iff (!rst_ns)
    !env_q |-> !data_q);

endmodule

// File: rtl/rxd_serial_port.sv
module rxd_serial_port #(
  parameter int LEN_W    = 8,
  parameter int HALF_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_en,
  input  logic             acq_done,
  input  logic             dem_stb,
  input  logic             dem_bit,
  input  logic [LEN_W-1:0] hdr_len,
  input  logic             crc_done,
  input  logic             crc_ok,
  input  logic             pn_lost,
  input  logic             cfg_ignore_crc,
  input  logic             cfg_env_low,
  output logic             ser_data,
  output logic             ser_clk,
  output logic             ser_valid
);

  logic [1:0] rst_sync_q;
  logic       rst_ns;
  logic       run_nx;
  logic       env_nx;
  logic       take;
  logic       env_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ns = rst_sync_q[1];

  rxd_ctrl #(.LEN_W(LEN_W)) i_ctrl (
    .clk            (clk),
    .rst_ns         (rst_ns),
    .rx_en          (rx_en),
    .acq_done       (acq_done),
    .dem_stb        (dem_stb),
    .hdr_len        (hdr_len),
    .crc_done       (crc_done),
    .crc_ok         (crc_ok),
    .pn_lost        (pn_lost),
    .cfg_ignore_crc (cfg_ignore_crc),
    .bclk           (ser_clk),
    .run_nx         (run_nx),
    .env_nx         (env_nx),
    .take           (take)
  );

  rxd_bitclk #(.HALF_CYC(HALF_CYC)) i_bitclk (
    .clk    (clk),
    .rst_ns (rst_ns),
    .run    (run_nx),
    .stb    (dem_stb),
    .bclk   (ser_clk)
  );

  rxd_drive i_drive (
    .clk         (clk),
    .rst_ns      (rst_ns),
    .env_nx      (env_nx),
    .take        (take),
    .dem_bit     (dem_bit),
    .cfg_env_low (cfg_env_low),
    .ser_data    (ser_data),
    .env_act     (env_act),
    .ser_valid   (ser_valid)
  );

  // R1: standby outputs after the enable drops
  a_r1_standby_out: assert property (@(posedge clk) disable iff (!rst_ns)
    !rx_en |=> (!env_act && ser_clk && !ser_data));

  // R6: loss of PN tracking closes the envelope at once
  a_r6_pn_abort: assert property (@(posedge clk) disable iff (!rst_ns)
    (env_act && pn_lost) |=> (!env_act && ser_clk));

  // R4: inside the envelope the data changes only with a falling bit clock
  a_r4_data_on_fall: assert property (@(posedge clk) disable iff (!rst_ns)
    (env_act && $past(env_act) && !$stable(ser_data)) |-> $fell(ser_clk));

  // R12: a strobe coinciding with PN loss does not reach the data line
  a_r12_abort_wins: assert property (@(posedge clk) disable iff (!rst_ns)
    (dem_stb && pn_lost) |=> !ser_data);

endmodule

// File: tb/test_rxd_serial_port.sv
module test_rxd_serial_port;

  localparam int CLK_PERIOD = 10;
  localparam int LEN_W      = 8;
  localparam int HALF_CYC   = 2;
  localparam int GAP        = 6;
  localparam int NVEC       = 7;

  // [23:20] bytes, [19] crc ok, [18] ignore, [17] low polarity,
  // [16:15] abort kind (0 none, 1 pn lost, 2 enable drop), [14:8] abort bit, [7:0] seed
  localparam logic [23:0] PKT_TAB [NVEC] = '{
    {4'd2, 1'b1, 1'b0, 1'b0, 2'd0, 7'd0,  8'hA5},
    {4'd1, 1'b0, 1'b1, 1'b0, 2'd0, 7'd0,  8'h3C},
    {4'd1, 1'b0, 1'b0, 1'b0, 2'd0, 7'd0,  8'h55},
    {4'd0, 1'b1, 1'b0, 1'b0, 2'd0, 7'd0,  8'h00},
    {4'd2, 1'b1, 1'b0, 1'b1, 2'd0, 7'd0,  8'h96},
    {4'd3, 1'b1, 1'b0, 1'b0, 2'd1, 7'd10, 8'h11},
    {4'd2, 1'b1, 1'b0, 1'b1, 2'd2, 7'd5,  8'hC3}
  };

  logic             clk;
  logic             rst_n;
  logic             rx_en;
  logic             acq_done;
  logic             dem_stb;
  logic             dem_bit;
  logic [LEN_W-1:0] hdr_len;
  logic             crc_done;
  logic             crc_ok;
  logic             pn_lost;
  logic             cfg_ignore_crc;
  logic             cfg_env_low;
  logic             ser_data;
  logic             ser_clk;
  logic             ser_valid;

  int checks;
  int failures;

  rxd_serial_port #(.LEN_W(LEN_W), .HALF_CYC(HALF_CYC)) i_rxd_serial_port (
    .clk            (clk),
    .rst_n          (rst_n),
    .rx_en          (rx_en),
    .acq_done       (acq_done),
    .dem_stb        (dem_stb),
    .dem_bit        (dem_bit),
    .hdr_len        (hdr_len),
    .crc_done       (crc_done),
    .crc_ok         (crc_ok),
    .pn_lost        (pn_lost),
    .cfg_ignore_crc (cfg_ignore_crc),
    .cfg_env_low    (cfg_env_low),
    .ser_data       (ser_data),
    .ser_clk        (ser_clk),
    .ser_valid      (ser_valid)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic env_lvl(input logic active);
    return active ^ cfg_env_low;
  endfunction

  // one header-phase strobe: clock moves, data and envelope stay idle
  task automatic header_bit(input logic b);
    dem_stb = 1'b1; dem_bit = b;
    step();
    dem_stb = 1'b0;
    check("R2 header clock low", ser_clk, 0);
    check("R3 header data zero", ser_data, 0);
    check("R3 header envelope", ser_valid, env_lvl(1'b0));
    step(HALF_CYC);
    check("R2 header clock high", ser_clk, 1);
    step(GAP - HALF_CYC - 1);
  endtask

  task automatic run_pkt(input logic [23:0] v);
    int       nbytes;
    logic     open;
    int       kind;
    int       abort_at;
    logic [7:0] rx_byte;
    logic       stop;
    nbytes         = int'(v[23:20]);
    crc_ok         = v[19];
    cfg_ignore_crc = v[18];
    cfg_env_low    = v[17];
    kind           = int'(v[16:15]);
    abort_at       = int'(v[14:8]);
    open           = (nbytes != 0) && (v[19] || v[18]);
    stop           = 1'b0;
    rx_byte        = '0;
    rx_en = 1'b1;
    step();
    acq_done = 1'b1;
    step();
    acq_done = 1'b0;
    step();
    for (int h = 0; h < 3; h++) header_bit(h[0]);
    hdr_len  = LEN_W'(nbytes);
    crc_done = 1'b1;
    step();
    crc_done = 1'b0;
    // R3 R8 R9 R10 R11: envelope opens only on a usable header
    check("R3 R8 R9 R10 R11 envelope after crc", ser_valid, env_lvl(open));
    if (!open) begin
      dem_stb = 1'b1; dem_bit = 1'b1;
      step();
      dem_stb = 1'b0;
      check("R8 R11 no clock after rejected header", ser_clk, 1);
      check("R8 R11 envelope stays shut", ser_valid, env_lvl(1'b0));
      check("R8 R11 data stays zero", ser_data, 0);
    end else begin
      for (int i = 0; i < nbytes * 8; i++) begin
        logic [7:0] tx_byte;
        logic       b;
        if (stop) continue;
        tx_byte = v[7:0] + 8'(i / 8 * 37);
        b       = tx_byte[i % 8];
        if (kind != 0 && i == abort_at) begin
          if (kind == 1) pn_lost = 1'b1;
          else           rx_en   = 1'b0;
          step();
          pn_lost = 1'b0;
          check(kind == 1 ? "R6 envelope closed" : "R7 envelope closed", ser_valid, env_lvl(1'b0));
          check(kind == 1 ? "R6 data zero" : "R7 data zero", ser_data, 0);
          check(kind == 1 ? "R6 clock high" : "R7 clock high", ser_clk, 1);
          stop = 1'b1;
        end else begin
          dem_stb = 1'b1; dem_bit = b;
          step();
          dem_stb = 1'b0;
          check("R4 data on strobe", ser_data, b);
          check("R2 payload clock low", ser_clk, 0);
          rx_byte[i % 8] = ser_data;
          step(HALF_CYC);
          check("R2 payload clock high", ser_clk, 1);
          check("R4 data stable at rise", ser_data, b);
          check("R5 R10 envelope at rise", ser_valid, env_lvl(1'b1));
          if (i % 8 == 7) check("R4 byte order lsb first", rx_byte, tx_byte);
          if (i == nbytes * 8 - 1) begin
            step();
            check("R5 envelope closes after last bit", ser_valid, env_lvl(1'b0));
            check("R5 data zero after close", ser_data, 0);
          end else begin
            step(GAP - HALF_CYC - 1);
          end
        end
      end
    end
    rx_en = 1'b0;
    step(3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    checks = 0; failures = 0;
    rst_n = 1'b0; rx_en = 1'b0; acq_done = 1'b0; dem_stb = 1'b0; dem_bit = 1'b0;
    hdr_len = '0; crc_done = 1'b0; crc_ok = 1'b0; pn_lost = 1'b0;
    cfg_ignore_crc = 1'b0; cfg_env_low = 1'b0;
    step(3);
    check("R1 reset clock idle", ser_clk, 1);
    check("R1 reset data zero", ser_data, 0);
    check("R1 reset envelope", ser_valid, 0);
    rst_n = 1'b1;
    step(4);

    for (int k = 0; k < NVEC; k++) run_pkt(PKT_TAB[k]);

    // R1: acquisition and strobes are ignored in standby
    cfg_env_low = 1'b0;
    acq_done = 1'b1; step(); acq_done = 1'b0;
    dem_stb = 1'b1; dem_bit = 1'b1; step(); dem_stb = 1'b0;
    check("R1 standby clock", ser_clk, 1);
    check("R1 standby data", ser_data, 0);
    check("R1 standby envelope", ser_valid, 0);
    crc_done = 1'b1; crc_ok = 1'b1; hdr_len = 8'd1; step(); crc_done = 1'b0;
    check("R1 standby ignores crc", ser_valid, 0);
    step(2);

    // R12: strobe and PN loss on the same edge
    cfg_ignore_crc = 1'b0;
    rx_en = 1'b1; step();
    acq_done = 1'b1; step(); acq_done = 1'b0; step();
    header_bit(1'b0);
    hdr_len = 8'd1; crc_ok = 1'b1; crc_done = 1'b1; step(); crc_done = 1'b0;
    check("R3 envelope open before collision", ser_valid, 1);
    for (int i = 0; i < 3; i++) begin
      dem_stb = 1'b1; dem_bit = 1'b0; step(); dem_stb = 1'b0;
      step(GAP - 1);
    end
    dem_stb = 1'b1; dem_bit = 1'b1; pn_lost = 1'b1;
    step();
    dem_stb = 1'b0; pn_lost = 1'b0;
    check("R12 discarded bit data", ser_data, 0);
    check("R12 clock high", ser_clk, 1);
    check("R12 envelope closed", ser_valid, 0);
    dem_stb = 1'b1; dem_bit = 1'b1; step(); dem_stb = 1'b0;
    check("R6 hunting after loss, clock idle", ser_clk, 1);
    rx_en = 1'b0;
    step(3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule